// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is the datapath core of a small 8-bit processor. In one cycle it turns an accumulator operand and a second operand into an 8-bit result, and it computes the next value of five status flags. Those flags are sign, zero, auxiliary (half) carry, even parity and carry. The flags live in a register inside the block. That register loads on the rising clock edge only while the flag-write enable is high. The stored carry and auxiliary carry feed back into the operations that consume them: add or subtract with carry, the rotates through carry, carry complement and decimal adjust.

The operation set covers the following:
- 8-bit add and subtract, each with and without carry or borrow in.
- Compare, which is a subtract that keeps the accumulator.
- Bitwise AND, OR and XOR.
- Four rotates, two circular and two through the carry.
- Accumulator complement, carry complement and carry set.
- BCD decimal adjust.
- Single-byte increment and decrement.

A separate 16-bit pair path adds two register pairs, touching only the carry flag. It also increments or decrements a pair without touching any flag. The result and the pair result are combinational from the inputs and the stored flags.

Top module: `byte_alu`

## Requirements
- R1: While rst_ni is low the flag register clears, so flags_o reads 0. The flag vector layout is flags_o[4]=sign, [3]=zero, [2]=auxiliary carry, [1]=parity, [0]=carry.
- R2: With flag_we_i low, flags_o keeps its value across the clock edge whatever the operation. With it high, flags_o takes the operation's next flags.
- R3: This requirement covers add (op 0) and add with carry (op 1).
  - res_o = a_i + b_i (+ stored carry for op 1), modulo 256.
  - Carry is the carry out of bit 7, and auxiliary carry is the carry out of bit 3.
  - Sign copies result bit 7, zero is set when the result is 0, and parity is set when the result has an even number of ones.
- R4: This requirement covers subtract (op 2) and subtract with borrow (op 3).
  - res_o = a_i - b_i (- stored carry for op 3), modulo 256.
  - Carry is set when b_i plus the borrow in exceeds a_i.
  - Auxiliary carry is the carry out of bit 3 of a_i[3:0] + ~b_i[3:0] + (1 - borrow in).
  - Sign, zero and parity follow the R3 rules.
- R5: Compare (op 4) returns res_o = a_i. It sets its flags as subtract would, so carry means a_i < b_i, zero means a_i == b_i, and both are clear when a_i > b_i.
- R6: AND (op 5), OR (op 6) and XOR (op 7) set sign, zero and parity from the result. AND forces carry to 0 and auxiliary carry to 1. OR and XOR force both to 0.
- R7: Circular rotate left (op 8) moves bit 7 into bit 0 and into carry. Circular rotate right (op 9) moves bit 0 into bit 7 and into carry. Only carry changes.
- R8: Rotate left through carry (op 10) moves bit 7 into carry and the old carry into bit 0. Rotate right through carry (op 11) moves bit 0 into carry and the old carry into bit 7. Only carry changes.
- R9: The three single-purpose operations behave as follows, and each returns res_o = a_i except complement:
  - Complement (op 12) returns ~a_i and changes no flag.
  - Carry complement (op 13) inverts carry only.
  - Carry set (op 14) sets carry only.
- R10: Decimal adjust (op 15) works in two steps and updates all five flags.
  - First step: if a_i[3:0] > 9 or the stored auxiliary carry is set, add 0x06. Auxiliary carry becomes the carry out of bit 3 of that addition, or 0 when no addition is made.
  - Second step: if the intermediate high nibble > 9, the stored carry is set, or the first step carried out of bit 7, add 0x60.
  - Carry becomes the old carry OR any carry out of bit 7. Sign, zero and parity follow the result.
- R11: Increment (op 16) and decrement (op 17) return a_i ± 1 modulo 256 and keep carry. Auxiliary carry is set on increment when a_i[3:0] == 0xF, and on decrement when a_i[3:0] != 0. Sign, zero and parity follow the result.
- R12: The pair path works as follows:
  - Pair add (op 18) gives pair_res_o = pair_a_i + pair_b_i modulo 65536. Carry becomes the carry out of bit 15, and no other flag changes.
  - Pair increment (op 19) and pair decrement (op 20) give pair_a_i ± 1 and change no flag.
  - For every other op, pair_res_o = pair_a_i.
- R13: Codes 21 to 31 give res_o = a_i and pair_res_o = pair_a_i, and leave flags_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| pair_a_i | input | 16 | First register-pair operand |
| pair_b_i | input | 16 | Second register-pair operand |
| flag_we_i | input | 1 | Flag register write enable |
| res_o | output | 8 | 8-bit result |
| pair_res_o | output | 16 | 16-bit pair result |
| flags_o | output | 5 | Stored flags {sign, zero, aux carry, parity, carry} |

## Verification
The properties assume op_i, a_i and flag_we_i are stable and known around each rising clock edge. The next-cycle flag checks rely on this, because they relate flags_o to the op_i, a_i and b_i that were sampled at the edge. The bench drives every input on the falling edge and holds it for a full cycle. It sweeps codes 0 to 22, so the two undefined codes are included. It toggles flag_we_i randomly so that the feedback of stored carry and auxiliary carry into later operations is exercised.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBB  = 5'd3,
    OP_CMP   = 5'd4,
    OP_AND   = 5'd5,
    OP_OR    = 5'd6,
    OP_XOR   = 5'd7,
    OP_ROL   = 5'd8,
    OP_ROR   = 5'd9,
    OP_ROLC  = 5'd10,
    OP_RORC  = 5'd11,
    OP_NOT   = 5'd12,
    OP_CFLIP = 5'd13,
    OP_CSET  = 5'd14,
    OP_DADJ  = 5'd15,
    OP_INC   = 5'd16,
    OP_DEC   = 5'd17,
    OP_PADD  = 5'd18,
    OP_PINC  = 5'd19,
    OP_PDEC  = 5'd20
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cy_i,
  input  logic            ac_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o,
  output logic            ac_o
);
  logic [DW-1:0] addend;
  logic          cin;
  logic          inv;
  logic [DW:0]   sum;
  logic [NW:0]   lo;

  logic          lo_fix, hi_fix;
  logic [DW:0]   adj1, adj2;
  logic [NW:0]   adj_lo;

  always_comb begin
    addend = b_i;
    cin    = 1'b0;
    inv    = 1'b0;
    case (op_i)
      OP_ADDC:                begin cin = cy_i; end
      OP_SUB, OP_CMP:         begin addend = ~b_i; cin = 1'b1;  inv = 1'b1; end
      OP_SUBB:                begin addend = ~b_i; cin = ~cy_i; inv = 1'b1; end
      OP_INC:                 begin addend = '0;   cin = 1'b1; end
      OP_DEC:                 begin addend = '1;   cin = 1'b0; end
      default: ;
    endcase
    sum = {1'b0, a_i} + {1'b0, addend} + {{DW{1'b0}}, cin};
    lo  = {1'b0, a_i[NW-1:0]} + {1'b0, addend[NW-1:0]} + {{NW{1'b0}}, cin};
  end

  // decimal adjust: two chained nibble corrections
  always_comb begin
    lo_fix = (a_i[NW-1:0] > 4'd9) || ac_i;
    adj_lo = {1'b0, a_i[NW-1:0]} + (lo_fix ? 5'd6 : 5'd0);
    adj1   = {1'b0, a_i} + (lo_fix ? 9'h006 : 9'h000);
    hi_fix = (adj1[DW-1:NW] > 4'd9) || cy_i || adj1[DW];
    adj2   = {1'b0, adj1[DW-1:0]} + (hi_fix ? 9'h060 : 9'h000);
  end

  always_comb begin
    if (op_i == OP_DADJ) begin
      res_o = adj2[DW-1:0];
      cy_o  = cy_i | adj1[DW] | adj2[DW];
      ac_o  = adj_lo[NW];
    end else begin
      res_o = sum[DW-1:0];
      cy_o  = sum[DW] ^ inv;
      ac_o  = lo[NW];
    end
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cy_i,
  output logic [DW-1:0]   res_o,
  output logic            cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_ROL:  begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_ROR:  begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_ROLC: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RORC: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      OP_NOT:  res_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_alu_pair.sv
module byte_alu_pair
  import byte_alu_pkg::*;
#(
  parameter int PW = 16
) (
  input  alu_op_e         op_i,
  input  logic [PW-1:0]   pa_i,
  input  logic [PW-1:0]   pb_i,
  output logic [PW-1:0]   res_o,
  output logic            cy_o
);
  logic [PW:0] wide;

  always_comb begin
    wide = {1'b0, pa_i};
    case (op_i)
      OP_PADD: wide = {1'b0, pa_i} + {1'b0, pb_i};
      OP_PINC: wide = {1'b0, pa_i + {{(PW-1){1'b0}}, 1'b1}};
      OP_PDEC: wide = {1'b0, pa_i - {{(PW-1){1'b0}}, 1'b1}};
      default: ;
    endcase
    res_o = wide[PW-1:0];
    cy_o  = wide[PW];
  end
endmodule

// File: rtl/byte_alu_flagreg.sv
module byte_alu_flagreg
  import byte_alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [PW-1:0]   pair_a_i,
  input  logic [PW-1:0]   pair_b_i,
  input  logic            flag_we_i,
  output logic [DW-1:0]   res_o,
  output logic [PW-1:0]   pair_res_o,
  output logic [4:0]      flags_o
);
  alu_op_e    op;
  alu_flags_t flags_q, flags_d;
  logic [DW-1:0] ar_res, lg_res, szp_src;
  logic          ar_cy, ar_ac, lg_cy, pr_cy, szp_en;

  assign op = alu_op_e'(op_i);

  byte_alu_arith u_arith (
    .op_i (op), .a_i (a_i), .b_i (b_i),
    .cy_i (flags_q.cy), .ac_i (flags_q.ac),
    .res_o (ar_res), .cy_o (ar_cy), .ac_o (ar_ac)
  );

  byte_alu_logic u_logic (
    .op_i (op), .a_i (a_i), .b_i (b_i), .cy_i (flags_q.cy),
    .res_o (lg_res), .cy_o (lg_cy)
  );

  byte_alu_pair #(.PW(PW)) u_pair (
    .op_i (op), .pa_i (pair_a_i), .pb_i (pair_b_i),
    .res_o (pair_res_o), .cy_o (pr_cy)
  );

  always_comb begin
    res_o   = a_i;
    flags_d = flags_q;
    szp_en  = 1'b0;
    szp_src = ar_res;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_DADJ: begin
        res_o      = ar_res;
        flags_d.cy = ar_cy;
        flags_d.ac = ar_ac;
        szp_en     = 1'b1;
      end
      OP_CMP: begin
        flags_d.cy = ar_cy;
        flags_d.ac = ar_ac;
        szp_en     = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_o      = ar_res;
        flags_d.ac = ar_ac;
        szp_en     = 1'b1;
      end
      OP_AND: begin
        res_o      = lg_res;
        flags_d.cy = 1'b0;
        flags_d.ac = 1'b1;
        szp_en     = 1'b1;
        szp_src    = lg_res;
      end
      OP_OR, OP_XOR: begin
        res_o      = lg_res;
        flags_d.cy = 1'b0;
        flags_d.ac = 1'b0;
        szp_en     = 1'b1;
        szp_src    = lg_res;
      end
      OP_ROL, OP_ROR, OP_ROLC, OP_RORC: begin
        res_o      = lg_res;
        flags_d.cy = lg_cy;
      end
      OP_NOT:   res_o = lg_res;
      OP_CFLIP: flags_d.cy = ~flags_q.cy;
      OP_CSET:  flags_d.cy = 1'b1;
      OP_PADD:  flags_d.cy = pr_cy;
      default: ;
    endcase
    if (szp_en) begin
      flags_d.s = szp_src[DW-1];
      flags_d.z = (szp_src == '0);
      flags_d.p = ~^szp_src;
    end
  end

  byte_alu_flagreg u_flags (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (flag_we_i),
    .d_i (flags_d), .q_o (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic          flag_we_i,
  input logic [DW-1:0] res_o,
  input logic [4:0]    flags_o
);
  logic szp_op;
  assign szp_op = (op_i == OP_ADD) || (op_i == OP_ADDC) || (op_i == OP_SUB) ||
                  (op_i == OP_SUBB) || (op_i == OP_AND) || (op_i == OP_OR) ||
                  (op_i == OP_XOR) || (op_i == OP_INC) || (op_i == OP_DEC) ||
                  (op_i == OP_DADJ);

  AST_HOLD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o)); // R2

  AST_SZP_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && szp_op) |=> (flags_o[3] == ($past(res_o) == '0)) &&
      (flags_o[1] == ~^$past(res_o)) && (flags_o[4] == $past(res_o[DW-1]))); // R3

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> (res_o == a_i)); // R5

  AST_CMP_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_CMP && a_i == b_i) |=> (flags_o[3] && !flags_o[0])); // R5

  AST_AND_AUX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_AND) |=> (flags_o[2] && !flags_o[0])); // R6

  AST_OR_XOR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == OP_OR || op_i == OP_XOR)) |=> (!flags_o[2] && !flags_o[0])); // R6

  AST_ROT_ONLY_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= OP_ROL && op_i <= OP_RORC) |=> $stable(flags_o[4:1])); // R7

  AST_NOT_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_NOT) |=> $stable(flags_o)); // R9

  AST_CFLIP_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_CFLIP) |=> (flags_o[0] != $past(flags_o[0])) && $stable(flags_o[4:1])); // R9

  AST_INCDEC_KEEP_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[0])); // R11

  AST_PAIR_STEP_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == OP_PINC || op_i == OP_PDEC)) |=> $stable(flags_o)); // R12

  AST_UNDEF_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i > OP_PDEC) |=> $stable(flags_o)); // R13
endmodule

bind byte_alu byte_alu_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op_i), .a_i (a_i), .b_i (b_i),
  .flag_we_i (flag_we_i), .res_o (res_o), .flags_o (flags_o)
);

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  a = '0, b = '0;
  logic [15:0] pa = '0, pb = '0;
  logic        we = 1'b0;
  logic [7:0]  res;
  logic [15:0] pres;
  logic [4:0]  flags;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] mflags = '0;

  always #5 clk = ~clk;

  byte_alu dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .op_i (op), .a_i (a), .b_i (b),
    .pair_a_i (pa), .pair_b_i (pb), .flag_we_i (we),
    .res_o (res), .pair_res_o (pres), .flags_o (flags)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int par_even(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return (c % 2 == 0) ? 1 : 0;
  endfunction

  // behavioural reference from the requirements
  function automatic void ref_eval(input int opc, input int av, input int bv,
                                   input int pav, input int pbv, input logic [4:0] fin,
                                   output int r, output int pr, output logic [4:0] fo);
    int s, z, ac, p, cy, t, bin, lo, c1, szp, src;
    s = fin[4]; z = fin[3]; ac = fin[2]; p = fin[1]; cy = fin[0];
    r = av; pr = pav; szp = 0; src = 0;
    case (opc)
      0, 1: begin
        bin = (opc == 1) ? cy : 0;
        t = av + bv + bin; r = t & 255; cy = (t > 255);
        ac = ((av & 15) + (bv & 15) + bin) > 15; szp = 1; src = r;
      end
      2, 3, 4: begin
        bin = (opc == 3) ? cy : 0;
        t = (av - bv - bin) & 255; cy = ((bv + bin) > av);
        ac = ((av & 15) + ((~bv) & 15) + 1 - bin) > 15; szp = 1; src = t;
        if (opc != 4) r = t;
      end
      5: begin r = av & bv; cy = 0; ac = 1; szp = 1; src = r; end
      6: begin r = av | bv; cy = 0; ac = 0; szp = 1; src = r; end
      7: begin r = av ^ bv; cy = 0; ac = 0; szp = 1; src = r; end
      8:  begin r = ((av << 1) | (av >> 7)) & 255; cy = av >> 7; end
      9:  begin r = (av >> 1) | ((av & 1) << 7);   cy = av & 1;  end
      10: begin r = ((av << 1) & 255) | cy;          cy = av >> 7; end
      11: begin r = (av >> 1) | (cy << 7);           cy = av & 1;  end
      12: r = (~av) & 255;
      13: cy = (cy == 0) ? 1 : 0;
      14: cy = 1;
      15: begin
        t = av; lo = av & 15;
        if (lo > 9 || ac != 0) begin t = t + 6; ac = (lo + 6) > 15; end
        else ac = 0;
        c1 = (t > 255); t = t & 255;
        if (((t >> 4) > 9) || cy != 0 || c1 != 0) t = t + 'h60;
        cy = (cy != 0 || c1 != 0 || t > 255) ? 1 : 0;
        r = t & 255; szp = 1; src = r;
      end
      16: begin r = (av + 1) & 255; ac = ((av & 15) == 15); szp = 1; src = r; end
      17: begin r = (av - 1) & 255; ac = ((av & 15) != 0); szp = 1; src = r; end
      18: begin t = pav + pbv; pr = t & 65535; cy = (t > 65535); end
      19: pr = (pav + 1) & 65535;
      20: pr = (pav - 1) & 65535;
      default: ;
    endcase
    if (szp != 0) begin s = (src >> 7) & 1; z = (src == 0); p = par_even(src); end
    fo = {s[0], z[0], ac[0], p[0], cy[0]};
  endfunction

  task automatic step(input int opc, input int av, input int bv, input int pav,
                      input int pbv, input logic wen, input string tag);
    int er, ep;
    logic [4:0] ef;
    @(negedge clk);
    op = opc[4:0]; a = av[7:0]; b = bv[7:0]; pa = pav[15:0]; pb = pbv[15:0]; we = wen;
    #1;
    ref_eval(opc, av & 255, bv & 255, pav & 65535, pbv & 65535, mflags, er, ep, ef);
    chk(tag, "res_o", int'(res), er);
    chk(tag, "pair_res_o", int'(pres), ep);
    chk(tag, "flags_o", int'(flags), int'(mflags));
    @(posedge clk);
    if (wen) mflags = ef;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1", "flags_o in reset", int'(flags), 0);
    rst_ni = 1'b1;
    mflags = '0;
    // R3: 0x3A + 0xC6 wraps to zero with both carries
    step(0, 'h3A, 'hC6, 0, 0, 1, "R3");
    step(14, 0, 0, 0, 0, 1, "R9");           // carry set
    step(1, 'h10, 'h20, 0, 0, 1, "R3");      // add with carry -> 0x31
    step(14, 0, 0, 0, 0, 1, "R9");
    step(3, 'h50, 'h20, 0, 0, 1, "R4");      // borrow in -> 0x2F
    step(2, 'h10, 'h20, 0, 0, 1, "R4");      // underflow sets carry
    step(4, 'h22, 'h22, 0, 0, 1, "R5");      // equal
    step(4, 'h10, 'h80, 0, 0, 1, "R5");      // less
    step(4, 'h90, 'h01, 0, 0, 1, "R5");      // greater
    step(5, 'hF0, 'h3C, 0, 0, 1, "R6");
    step(6, 'h00, 'h00, 0, 0, 1, "R6");
    step(7, 'hAA, 'h55, 0, 0, 1, "R6");
    step(8, 'h81, 0, 0, 0, 1, "R7");
    step(9, 'h01, 0, 0, 0, 1, "R7");
    step(10, 'h80, 0, 0, 0, 1, "R8");
    step(11, 'h01, 0, 0, 0, 1, "R8");
    step(11, 'h00, 0, 0, 0, 1, "R8");
    step(12, 'h5A, 0, 0, 0, 1, "R9");
    step(13, 0, 0, 0, 0, 1, "R9");
    step(13, 0, 0, 0, 0, 1, "R9");
    step(0, 'h00, 'h00, 0, 0, 1, "R10");     // clear carries
    step(15, 'h9B, 0, 0, 0, 1, "R10");       // -> 0x01, carry
    step(15, 'hFF, 0, 0, 0, 1, "R10");
    step(0, 'h00, 'h00, 0, 0, 1, "R10");
    step(15, 'h45, 0, 0, 0, 1, "R10");       // no adjust
    step(16, 'hFF, 0, 0, 0, 1, "R11");
    step(17, 'h00, 0, 0, 0, 1, "R11");
    step(16, 'h0F, 0, 0, 0, 1, "R11");
    step(18, 0, 0, 'hFFFF, 'h0001, 1, "R12");
    step(19, 0, 0, 'hFFFF, 0, 1, "R12");
    step(20, 0, 0, 'h0000, 0, 1, "R12");
    step(21, 'h33, 'h44, 'h1234, 'h9, 1, "R13");
    step(31, 'h33, 'h44, 'h1234, 'h9, 1, "R13");
    step(2, 'h01, 'h02, 0, 0, 0, "R2");      // write disabled
    step(14, 0, 0, 0, 0, 0, "R2");
    step(12, 'h00, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 4000; i++) begin
      step(int'($urandom_range(0, 22)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 65535)), ($urandom_range(0, 3) != 0), "R2_R3_R12_random");
    end
    step(13, 0, 0, 0, 0, 0, "R2");
    finish_run();
  end
endmodule